// File: doc/BRIEF.md
# Multiplexed Address/Data Memory Bus Front-End

This block is the device-side edge of a memory that shares one 16-bit pin group between the low address and the data. At the start of an access, the host drives the low address on the shared lines and pulls an active-low address strobe. The upper address arrives on its own dedicated pins. The block joins the two parts into one word address, where bit 0 selects a 16-bit word. In the data phase that follows, the same lines carry write data inward or read data outward, and the block produces the output-enable for the shared lines and for a ready/wait line.

Address capture has two styles, chosen by a mode input that is read when each access begins. In clocked capture, the address is taken once, at the first clock edge that finds the strobe low, and is then held for the rest of the access. In transparent capture, the address follows the shared lines for as long as the strobe stays low, and it freezes at the value last seen when the strobe rises.

On the core side, the block presents a simple port: the word address, a one-cycle read strobe, a one-cycle write strobe, and the write word that goes with it. All pins are sampled on the system clock. The address width is a parameter; 22, 23 and 24 bits suit the three array sizes.

Top module: `admux_front`

## Requirements
- R1: `word_addr` is `{addr_hi, low16}`, where low16 is the value captured from `dq_in` and `addr_hi` holds the bits from 16 up to ADDR_W-1.
- R2: With clocked capture (`sync_mode`=1 at access start), the address is taken at the first rising clock edge with `ce_n`=0 and `adv_n`=0. Later edges within the same strobe do not change `word_addr`.
- R3: With transparent capture (`sync_mode`=0), `word_addr` follows `{addr_hi,dq_in}` in the same cycle while `ce_n`=0 and `adv_n`=0. After `adv_n` rises, it holds the value sampled at the last edge on which the strobe was low.
- R4: While `adv_n`=1, changes on `dq_in` or `addr_hi` never alter `word_addr`.
- R5: `dq_oe`=1 exactly when `ce_n`=0, `oe_n`=0 and `adv_n`=1. While it is set, `dq_out` equals `rd_data`; otherwise `dq_out` is 0.
- R6: `wait_oe` is 0 whenever `ce_n`=1. `wait_out` passes `wait_in` through.
- R7: An access begins on the first cycle with `ce_n`=0 and `adv_n`=0 after a cycle in which either was 1. `sync_mode` is read only in that cycle, and changing it later in the access has no effect.
- R8: `rd_stb` is a one-cycle pulse on the first cycle of a read phase, meaning `ce_n`=0, `adv_n`=1, `oe_n`=0, with an address captured since the last deselect.
- R9: `wr_stb` pulses for one cycle when `we_n` is seen high after a data-phase cycle with `we_n`=0, while selected with an address captured. `wr_data` is then the `dq_in` value sampled at the last clock edge with `we_n`=0.
- R10: A cycle with `ce_n`=1 discards the captured-address state. A later data phase with no new strobe gives neither `rd_stb` nor `wr_stb`.
- R11: After reset, `word_addr` is 0, both strobes are low, `dq_oe` is 0, and clocked capture is the default mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = clocked capture, 0 = transparent capture |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr_hi | input | ADDR_W-16 | Dedicated upper address pins |
| dq_in | input | 16 | Shared lines, inward value |
| dq_out | output | 16 | Shared lines, outward value |
| dq_oe | output | 1 | Drive enable for the shared lines |
| wait_in | input | 1 | Ready/wait level from the core |
| wait_out | output | 1 | Ready/wait pin value |
| wait_oe | output | 1 | Drive enable for the ready/wait pin |
| rd_data | input | 16 | Read word from the core |
| word_addr | output | ADDR_W | Word address to the core |
| rd_stb | output | 1 | Read request pulse |
| wr_stb | output | 1 | Write request pulse |
| wr_data | output | 16 | Write word to the core |

## Verification
The assertions check several behaviours on every cycle. The address stays frozen across consecutive cycles with the strobe high. Both strobes last a single cycle. No strobe appears right after a deselect cycle. A read pulse always coincides with the bus being driven. The wait line floats after deselect. Other behaviours depend on what happened earlier in the access, so only the bench's scenarios can show them: the first-edge-only capture, the transparent flow-through and its freeze value, the mode being sampled at access start, and the pairing of write data with the rising write enable. The bench's per-cycle reference model covers these.

// File: rtl/admux_front.sv
module admux_front #(
  parameter int ADDR_W = 24,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-DQ_W-1:0] addr_hi,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  input  logic              wait_in,
  output logic              wait_out,
  output logic              wait_oe,
  input  logic [DQ_W-1:0]   rd_data,
  output logic [ADDR_W-1:0] word_addr,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [DQ_W-1:0]   wr_data
);
  localparam int HI_W = ADDR_W - DQ_W;

  logic            adv_q, ce_q, cap_q, mode_q, rd_q, wlow_q;
  logic [DQ_W-1:0] lo_q, wd_q;
  logic [HI_W-1:0] hi_q;

  wire sel       = ~ce_n;
  wire start     = sel & ~adv_n & (adv_q | ce_q);
  wire mode_sync = start ? sync_mode : mode_q;
  wire take      = sel & ~adv_n & (~mode_sync | start | ~cap_q);
  wire data_ph   = sel & adv_n;
  wire rd_act    = data_ph & ~oe_n & cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q  <= 1'b1;
      ce_q   <= 1'b1;
      cap_q  <= 1'b0;
      mode_q <= 1'b1;
      rd_q   <= 1'b0;
      wlow_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      wd_q   <= '0;
    end else begin
      adv_q  <= adv_n;
      ce_q   <= ce_n;
      rd_q   <= rd_act;
      wlow_q <= data_ph & ~we_n;
      if (!sel)      cap_q <= 1'b0;
      else if (take) cap_q <= 1'b1;
      if (sel) mode_q <= mode_sync;
      if (take) begin
        lo_q <= dq_in;
        hi_q <= addr_hi;
      end
      if (data_ph & ~we_n) wd_q <= dq_in;
    end
  end

  assign word_addr = (sel & ~adv_n & ~mode_sync) ? {addr_hi, dq_in} : {hi_q, lo_q};
  assign dq_oe     = data_ph & ~oe_n;
  assign dq_out    = dq_oe ? rd_data : '0;
  assign wait_oe   = sel;
  assign wait_out  = wait_in;
  assign rd_stb    = rd_act & ~rd_q;
  assign wr_stb    = data_ph & cap_q & we_n & wlow_q;
  assign wr_data   = wd_q;
endmodule

module admux_front_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              adv_n,
  input logic              dq_oe,
  input logic              wait_oe,
  input logic [ADDR_W-1:0] word_addr,
  input logic              rd_stb,
  input logic              wr_stb
);
  p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_n && $past(adv_n)) |-> $stable(word_addr));

  p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  p_rd_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> dq_oe);

  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_no_strobe_after_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (!rd_stb && !wr_stb));

  p_wait_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> !wait_oe);
endmodule

bind admux_front admux_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .dq_oe(dq_oe),
  .wait_oe(wait_oe), .word_addr(word_addr), .rd_stb(rd_stb), .wr_stb(wr_stb)
);

// File: tb/sim_admux_front.sv
`timescale 1ns/1ps
module sim_admux_front;
  localparam int AW = 24;
  localparam int HW = AW - 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 1'b1, ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [HW-1:0] addr_hi = '0;
  logic [15:0] dq_in = '0, rd_data = '0;
  logic wait_in = 1'b0;
  logic [15:0] dq_out, wr_data;
  logic dq_oe, wait_out, wait_oe, rd_stb, wr_stb;
  logic [AW-1:0] word_addr;

  always #5 clk = ~clk;

  admux_front #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ce_n(ce_n), .adv_n(adv_n),
    .oe_n(oe_n), .we_n(we_n), .addr_hi(addr_hi), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .wait_in(wait_in), .wait_out(wait_out), .wait_oe(wait_oe),
    .rd_data(rd_data), .word_addr(word_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R11";

  // reference model state
  logic [AW-1:0] m_addr = '0;
  bit m_have = 0, m_clocked = 1, m_pend_adv = 1, m_pend_ce = 1, m_wlow = 0, m_rd_prev = 0;
  logic [15:0] m_wd = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit opening();
    return !ce_n && !adv_n && (m_pend_adv || m_pend_ce);
  endfunction

  function automatic bit clocked_now();
    return opening() ? sync_mode : m_clocked;
  endfunction

  task automatic compare();
    logic [AW-1:0] ea;
    bit drv, rdp, wrp;
    ea  = (!ce_n && !adv_n && !clocked_now()) ? {addr_hi, dq_in} : m_addr;
    drv = !ce_n && !oe_n && adv_n;
    rdp = !ce_n && adv_n && !oe_n && m_have && !m_rd_prev;
    wrp = !ce_n && adv_n && m_have && we_n && m_wlow;
    chk(req, "word_addr", 32'(word_addr), 32'(ea));
    chk("R5", "dq_oe", 32'(dq_oe), 32'(drv));
    chk("R5", "dq_out", 32'(dq_out), drv ? 32'(rd_data) : 32'd0);
    chk("R6", "wait_oe", 32'(wait_oe), 32'(!ce_n));
    chk("R6", "wait_out", 32'(wait_out), 32'(wait_in));
    chk(req, "rd_stb", 32'(rd_stb), 32'(rdp));
    chk(req, "wr_stb", 32'(wr_stb), 32'(wrp));
    if (wrp) chk("R9", "wr_data", 32'(wr_data), 32'(m_wd));
  endtask

  task automatic advance();
    bit clk_mode, grab;
    clk_mode = clocked_now();
    grab = !ce_n && !adv_n && (!clk_mode || opening() || !m_have);
    if (grab) m_addr = {addr_hi, dq_in};
    m_rd_prev = !ce_n && adv_n && !oe_n && m_have;
    if (ce_n) m_have = 0; else if (grab) m_have = 1;
    if (!ce_n) m_clocked = clk_mode;
    if (!ce_n && adv_n && !we_n) m_wd = dq_in;
    m_wlow = !ce_n && adv_n && !we_n;
    m_pend_adv = adv_n;
    m_pend_ce = ce_n;
  endtask

  task automatic cyc(input logic c, input logic a, input logic o, input logic w,
                     input logic [HW-1:0] h, input logic [15:0] d);
    ce_n = c; adv_n = a; oe_n = o; we_n = w; addr_hi = h; dq_in = d;
    #1;
    compare();
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R11: reset state
    #1;
    chk("R11", "word_addr", 32'(word_addr), 32'd0);
    chk("R11", "rd_stb", 32'(rd_stb), 32'd0);
    chk("R11", "wr_stb", 32'(wr_stb), 32'd0);
    chk("R11", "dq_oe", 32'(dq_oe), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);

    // R1, R2: clocked capture, later edges ignored
    req = "R2"; sync_mode = 1;
    cyc(0, 0, 1, 1, 8'hA5, 16'h1234);
    cyc(0, 0, 1, 1, 8'h3C, 16'hBEEF);
    #1 chk("R1", "joined addr", 32'(word_addr), 32'h00A51234);
    // R4: data phase, address ignored; R9 write
    req = "R9";
    cyc(0, 1, 1, 0, 8'hFF, 16'hCAFE);
    cyc(0, 1, 1, 0, 8'h11, 16'hD00D);
    cyc(0, 1, 1, 1, 8'h22, 16'h7777);
    req = "R4";
    cyc(0, 1, 1, 1, 8'h33, 16'h5555);
    #1 chk("R4", "addr held", 32'(word_addr), 32'h00A51234);

    // R10: deselect then data phase without strobe
    req = "R10";
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);
    rd_data = 16'h9abc;
    cyc(0, 1, 0, 1, 8'h00, 16'h0000);
    cyc(0, 1, 1, 0, 8'h00, 16'h0101);
    cyc(0, 1, 1, 1, 8'h00, 16'h0202);
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);

    // R8, R5: clocked read
    req = "R8";
    cyc(0, 0, 1, 1, 8'h07, 16'h0F0F);
    cyc(0, 1, 1, 1, 8'h00, 16'hFFFF);
    rd_data = 16'h4321; wait_in = 1;
    cyc(0, 1, 0, 1, 8'h00, 16'h0000);
    #1 chk("R5", "read drive", 32'(dq_out), 32'h4321);
    cyc(0, 1, 0, 1, 8'h00, 16'h0000);
    cyc(0, 1, 1, 1, 8'h00, 16'h0000);
    cyc(0, 1, 0, 1, 8'h00, 16'h0000);
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);

    // R3: transparent capture
    req = "R3"; sync_mode = 0;
    cyc(0, 0, 1, 1, 8'h01, 16'h1111);
    cyc(0, 0, 1, 1, 8'h02, 16'h2222);
    cyc(0, 0, 1, 1, 8'h03, 16'h3333);
    cyc(0, 1, 1, 1, 8'h04, 16'h4444);
    #1 chk("R3", "freeze", 32'(word_addr), 32'h00033333);
    cyc(0, 1, 0, 1, 8'h00, 16'h0000);
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);

    // R7: mode read only at access start
    req = "R7"; sync_mode = 1;
    cyc(0, 0, 1, 1, 8'h55, 16'hAAAA);
    sync_mode = 0;
    cyc(0, 0, 1, 1, 8'h66, 16'hBBBB);
    cyc(0, 0, 1, 1, 8'h77, 16'hCCCC);
    #1 chk("R7", "mode kept", 32'(word_addr), 32'h0055AAAA);
    cyc(0, 1, 1, 1, 8'h00, 16'h0000);
    // new access via adv re-assertion picks transparent mode
    cyc(0, 0, 1, 1, 8'h12, 16'h3456);
    cyc(0, 0, 1, 1, 8'h12, 16'h789A);
    cyc(0, 1, 1, 1, 8'h00, 16'h0000);
    // access opened by ce falling while strobe already low
    sync_mode = 1;
    cyc(1, 0, 1, 1, 8'hC0, 16'hFACE);
    cyc(0, 0, 1, 1, 8'hC1, 16'hFEED);
    cyc(0, 0, 1, 1, 8'hC2, 16'hBEAD);
    cyc(0, 1, 1, 0, 8'h00, 16'h6060);
    cyc(0, 1, 1, 1, 8'h00, 16'h0000);
    cyc(1, 1, 1, 1, 8'h00, 16'h0000);

    // R1: sweep upper bits
    req = "R1";
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 1, 1, 8'(i * 37), 16'(i * 4099));
      cyc(0, 1, 1, 1, 8'hFF, 16'hFFFF);
      cyc(1, 1, 1, 1, 8'h00, 16'h0000);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule